// File: doc/BRIEF.md
# Predicated Vector Magnitude Comparator

This block compares the magnitudes of packed floating-point elements held in two vector operands, one lane at a time. Each lane gives one boolean answer: is |A| greater than |B|, or is |A| greater than or equal to |B|. A single select input picks between the two. The answers are packed into a byte-granular predicate. That predicate carries one bit per operand byte, so a lane of EW bits owns EW/8 predicate bits, and its answer sits in the lowest of them.

A governing predicate of the same shape chooses which lanes take part. A lane is active when the lowest bit of its group is set. Every inactive lane writes zeros into its whole group. When no lane is active at all, both operands are replaced by zeros before the compare. A 2-bit size code selects half, single or double precision lanes. Code 0 is rejected and raises an encoding-error flag.

A NaN in an active lane makes that lane false and raises an invalid-operation flag. The block has no less-than or less-or-equal mode. A caller gets those by swapping the two operands. All outputs are registered, one clock after the inputs are presented.

Top module: `vec_absmag_cmp`

## Requirements
- R1: While reset is low at a clock edge, the result predicate is forced to all zeros and both flags are forced low.
- R2: Results appear one clock after the inputs. The element width is 8 shifted left by the size code: code 1 selects 16-bit lanes, code 2 selects 32-bit lanes and code 3 selects 64-bit lanes.
- R3: The select input chooses the test: a value of 1 selects |A| >= |B| and a value of 0 selects |A| > |B|. The sign bits are ignored. +0 and -0 compare equal. Subnormals are ordered by magnitude. Infinity is the largest magnitude.
- R4: A lane's result is placed in the lowest predicate bit of its group, which is bit lane*EW/8. All higher bits of the group are zero.
- R5: A lane is active only when governing predicate bit lane*EW/8 is set. An inactive lane writes zeros into its whole group, whatever its operands hold.
- R6: If an active lane holds a NaN in either operand, that lane's result is 0 and the invalid-operation flag goes high. A NaN has an all-ones exponent and a non-zero fraction. A NaN in an inactive lane has no effect.
- R7: When the governing predicate is all zeros, the result predicate is all zeros and the invalid-operation flag is low, even if the operands hold NaNs.
- R8: Size code 0 sets the encoding-error flag. In that case the result predicate is all zeros and the invalid-operation flag is low.
- R9: Swapping the two operands under the greater-than test gives |A| < |B|. Swapping them under the greater-or-equal test gives |A| <= |B|.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_a | input | VL | First operand vector |
| vec_b | input | VL | Second operand vector |
| gov_pred | input | VL/8 | Governing predicate, one bit per byte |
| elem_size | input | 2 | Element size code (1=16, 2=32, 3=64 bits; 0 invalid) |
| op_ge | input | 1 | 1: greater-or-equal, 0: greater-than |
| res_pred | output | VL/8 | Result predicate |
| bad_size | output | 1 | Encoding error: size code 0 was given |
| invalid_op | output | 1 | A NaN was seen in an active lane |

## Verification
The bench fills every lane of each width with operand pairs whose outcome is already known, and uses a full governing mask. These pairs separate three things:
- magnitude ordering from signed ordering, by using opposite-sign pairs;
- the two tests, by using equal magnitudes and signed zeros;
- normal from special encodings, by using subnormals, infinities and NaNs.

Irregular masks that also set the upper bits of each group show whether activity is taken from the lowest bit only and whether the upper result bits stay clear. Further cases cover a NaN placed in a single lane, first inactive and then active. They also cover an all-zero mask over NaN operands, size code 0, and a swapped operand pair. These cases separate lane gating, the whole-vector zeroing and the encoding check from one another.

// File: rtl/absmag_pkg.sv
// Package: shared size codes and float-format helpers for the magnitude comparator.
// Assumes IEEE binary16/32/64 layouts (sign at MSB, then exponent, then fraction).
package absmag_pkg;

    typedef enum logic [1:0] {
        SZ_BAD  = 2'd0,
        SZ_HALF = 2'd1,
        SZ_SGL  = 2'd2,
        SZ_DBL  = 2'd3
    } elem_size_e;

    // Exponent field width for a supported element width.
    function automatic int exp_bits(input int ew);
        if (ew == 16)      return 5;
        else if (ew == 32) return 8;
        else               return 11;
    endfunction

endpackage

// File: rtl/absmag_lane.sv
// Module: absmag_lane
// One lane of the comparator. It clears both sign bits, detects NaNs and
// compares the remaining bit patterns as unsigned integers. That ordering
// matches float magnitude order for every non-NaN value, subnormals and
// infinities included. Purely combinational.
module absmag_lane #(
    parameter int EW = 16
) (
    input  logic [EW-1:0] op_a,
    input  logic [EW-1:0] op_b,
    input  logic          op_ge,
    output logic          hit,
    output logic          nan
);
    localparam int EXPW = absmag_pkg::exp_bits(EW);
    localparam int FRW  = EW - 1 - EXPW;

    logic [EW-2:0] mag_a, mag_b;
    logic          nan_a, nan_b;

    assign mag_a = op_a[EW-2:0];
    assign mag_b = op_b[EW-2:0];

    // NaN: exponent all ones with a non-zero fraction.
    assign nan_a = (&op_a[EW-2:FRW]) && (|op_a[FRW-1:0]);
    assign nan_b = (&op_b[EW-2:FRW]) && (|op_b[FRW-1:0]);

    // Magnitude test, forced false when either side is a NaN.
    always_comb begin
        nan = nan_a | nan_b;
        if (op_ge) hit = !nan && (mag_a >= mag_b);
        else       hit = !nan && (mag_a >  mag_b);
    end
endmodule

// File: rtl/absmag_slice.sv
// Module: absmag_slice
// All lanes of one element width across the vector. It applies the
// governing predicate: a lane is active when the lowest bit of its group is
// set. Results go into the lowest bit of each group. When no lane is
// active, both operands are replaced by zeros. Combinational.
module absmag_slice #(
    parameter int VL = 256,
    parameter int EW = 16
) (
    input  logic [VL-1:0]   vec_a,
    input  logic [VL-1:0]   vec_b,
    input  logic [VL/8-1:0] gov,
    input  logic            op_ge,
    output logic [VL/8-1:0] pred,
    output logic            nan_any
);
    localparam int LANES = VL / EW;
    localparam int PB    = EW / 8;
    localparam int PL    = VL / 8;

    logic [LANES-1:0] act, hit, nan;
    logic [VL-1:0]    opa, opb;
    logic             any_active;

    // Lane activity taken from the lowest predicate bit of each group.
    for (genvar i = 0; i < LANES; i++) begin : g_act
        assign act[i] = gov[i*PB];
    end

    assign any_active = |act;
    assign opa = any_active ? vec_a : '0;
    assign opb = any_active ? vec_b : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        absmag_lane #(.EW(EW)) u_lane (
            .op_a  (opa[i*EW +: EW]),
            .op_b  (opb[i*EW +: EW]),
            .op_ge (op_ge),
            .hit   (hit[i]),
            .nan   (nan[i])
        );
    end

    // Pack gated lane results into group-low predicate bits.
    always_comb begin
        pred = '0;
        for (int i = 0; i < LANES; i++) pred[i*PB] = act[i] & hit[i];
        nan_any = |(act & nan);
    end

    logic unused_hi;
    assign unused_hi = ^gov[PL-1:0];
endmodule

// File: rtl/vec_absmag_cmp.sv
// Module: vec_absmag_cmp (top)
// Predicated vector magnitude comparator. Three width slices (16/32/64)
// run in parallel. The size code selects one of them, and the result and
// flags are registered. Size code 0 gives a zero predicate and raises
// bad_size. Assumes VL is a multiple of 64.
module vec_absmag_cmp #(
    parameter int VL = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VL-1:0]   vec_a,
    input  logic [VL-1:0]   vec_b,
    input  logic [VL/8-1:0] gov_pred,
    input  logic [1:0]      elem_size,
    input  logic            op_ge,
    output logic [VL/8-1:0] res_pred,
    output logic            bad_size,
    output logic            invalid_op
);
    import absmag_pkg::*;

    localparam int PL = VL / 8;

    logic [PL-1:0] pred_w [4];
    logic          nan_w  [4];

    assign pred_w[0] = '0;
    assign nan_w[0]  = 1'b0;

    for (genvar k = 1; k < 4; k++) begin : g_width
        absmag_slice #(.VL(VL), .EW(8 << k)) u_slice (
            .vec_a   (vec_a),
            .vec_b   (vec_b),
            .gov     (gov_pred),
            .op_ge   (op_ge),
            .pred    (pred_w[k]),
            .nan_any (nan_w[k])
        );
    end

    // Register the selected width's result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pred   <= '0;
            bad_size   <= 1'b0;
            invalid_op <= 1'b0;
        end else begin
            res_pred   <= pred_w[elem_size];
            bad_size   <= (elem_size_e'(elem_size) == SZ_BAD);
            invalid_op <= nan_w[elem_size];
        end
    end
endmodule

// File: rtl/absmag_chk.sv
// Module: absmag_chk
// Assertion checker bound to vec_absmag_cmp. It checks group packing, lane
// gating, the all-inactive case and the size-0 encoding from the ports.
module absmag_chk #(
    parameter int VL = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VL/8-1:0] gov_pred,
    input logic [1:0]      elem_size,
    input logic [VL/8-1:0] res_pred,
    input logic            bad_size,
    input logic            invalid_op
);
    localparam int PL = VL / 8;

    // Mask of predicate bits that are not the lowest bit of a group.
    function automatic logic [PL-1:0] hi_mask(input int pb);
        logic [PL-1:0] m;
        for (int i = 0; i < PL; i++) m[i] = (i % pb) != 0;
        return m;
    endfunction

    localparam logic [PL-1:0] HI16 = hi_mask(2);
    localparam logic [PL-1:0] HI32 = hi_mask(4);
    localparam logic [PL-1:0] HI64 = hi_mask(8);

    assert_hi16_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_size == 2'd1) |=> ((res_pred & HI16) == '0));
    assert_hi32_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_size == 2'd2) |=> ((res_pred & HI32) == '0));
    assert_hi64_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_size == 2'd3) |=> ((res_pred & HI64) == '0));
    assert_inactive_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_size != 2'd0) |=> ((res_pred & ~$past(gov_pred)) == '0));
    assert_all_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gov_pred == '0) |=> (res_pred == '0 && !invalid_op));
    assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_size == 2'd0) |=> (bad_size && res_pred == '0 && !invalid_op));
    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |-> !bad_size);
endmodule

bind vec_absmag_cmp absmag_chk #(.VL(VL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gov_pred   (gov_pred),
    .elem_size  (elem_size),
    .res_pred   (res_pred),
    .bad_size   (bad_size),
    .invalid_op (invalid_op)
);

// File: tb/vec_absmag_cmp_tb.sv
module vec_absmag_cmp_tb;
    localparam int VL = 256;
    localparam int PL = VL / 8;
    localparam int NL = VL / 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [VL-1:0]   vec_a, vec_b;
    logic [PL-1:0]   gov_pred;
    logic [1:0]      elem_size;
    logic            op_ge;
    logic [PL-1:0]   res_pred;
    logic            bad_size, invalid_op;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vec_absmag_cmp #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .vec_a(vec_a), .vec_b(vec_b),
        .gov_pred(gov_pred), .elem_size(elem_size), .op_ge(op_ge),
        .res_pred(res_pred), .bad_size(bad_size), .invalid_op(invalid_op)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic        ge;
        logic [63:0] a;
        logic [63:0] b;
        logic        hit;
        logic        nan;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 1'b0, 64'h4000, 64'hBC00, 1'b1, 1'b0, 8'd3},
        '{2'd1, 1'b0, 64'hBC00, 64'h4000, 1'b0, 1'b0, 8'd3},
        '{2'd1, 1'b0, 64'h8000, 64'h0000, 1'b0, 1'b0, 8'd3},
        '{2'd1, 1'b1, 64'h8000, 64'h0000, 1'b1, 1'b0, 8'd3},
        '{2'd1, 1'b0, 64'h0002, 64'h8001, 1'b1, 1'b0, 8'd3},
        '{2'd1, 1'b0, 64'h7C00, 64'h7BFF, 1'b1, 1'b0, 8'd3},
        '{2'd1, 1'b1, 64'h7E00, 64'h3C00, 1'b0, 1'b1, 8'd6},
        '{2'd2, 1'b1, 64'hC0000000, 64'h40000000, 1'b1, 1'b0, 8'd3},
        '{2'd2, 1'b0, 64'hC0000000, 64'h40000000, 1'b0, 1'b0, 8'd3},
        '{2'd2, 1'b1, 64'h7F800000, 64'hFF800000, 1'b1, 1'b0, 8'd3},
        '{2'd2, 1'b0, 64'h3F800000, 64'h7FC00001, 1'b0, 1'b1, 8'd6},
        '{2'd3, 1'b0, 64'h8000000000000001, 64'h0, 1'b1, 1'b0, 8'd3},
        '{2'd3, 1'b1, 64'h3FF0000000000000, 64'hBFF0000000000001, 1'b0, 1'b0, 8'd3},
        '{2'd3, 1'b1, 64'h7FF0000000000001, 64'h0, 1'b0, 1'b1, 8'd6},
        '{2'd3, 1'b0, 64'h4000000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 8'd2},
        '{2'd2, 1'b0, 64'h00000001, 64'h80000000, 1'b1, 1'b0, 8'd3}
    };

    // Replicate one element across every lane of the given width.
    function automatic logic [VL-1:0] fill(input logic [1:0] sz, input logic [63:0] e);
        logic [VL-1:0] v;
        int ew;
        ew = 8 << sz;
        for (int i = 0; i < VL; i++) v[i] = e[i % ew];
        return v;
    endfunction

    // Expected predicate: the lane answer at the group-low bit when that gov bit is set.
    function automatic logic [PL-1:0] exp_pred(input logic [1:0] sz,
                                                input logic [PL-1:0] g,
                                                input logic [NL-1:0] hits);
        logic [PL-1:0] r;
        int pb;
        r = '0;
        pb = (8 << sz) / 8;
        for (int i = 0; i < PL / pb; i++) if (g[i*pb]) r[i*pb] = hits[i];
        return r;
    endfunction

    task automatic chk_pred(input string req, input logic [PL-1:0] act, input logic [PL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pred actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] sz, input logic ge,
                         input logic [VL-1:0] a, input logic [VL-1:0] b,
                         input logic [PL-1:0] g);
        @(negedge clk);
        elem_size = sz; op_ge = ge; vec_a = a; vec_b = b; gov_pred = g;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [VL-1:0] a;
        logic [PL-1:0] g;
        rst_n = 1'b0; elem_size = 2'd1; op_ge = 1'b1;
        vec_a = '1; vec_b = '0; gov_pred = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_pred("R1", res_pred, '0);
        chk_bit("R1", "bad_size", bad_size, 1'b0);
        chk_bit("R1", "invalid_op", invalid_op, 1'b0);
        rst_n = 1'b1;

        // R2 R3 R6 R9: table of uniform-lane vectors, full mask
        for (int t = 0; t < NV; t++) begin
            string rq;
            rq = $sformatf("R2/R%0d", TBL[t].req);
            apply(TBL[t].sz, TBL[t].ge, fill(TBL[t].sz, TBL[t].a), fill(TBL[t].sz, TBL[t].b), '1);
            chk_pred(rq, res_pred, exp_pred(TBL[t].sz, '1, {NL{TBL[t].hit}}));
            chk_bit(rq, "invalid_op", invalid_op, TBL[t].nan);
            chk_bit(rq, "bad_size", bad_size, 1'b0);
        end

        // R9: swap gives less-than
        apply(2'd1, 1'b0, fill(1, 64'h3C00), fill(1, 64'h4000), '1);
        chk_pred("R9", res_pred, '0);
        apply(2'd1, 1'b0, fill(1, 64'h4000), fill(1, 64'h3C00), '1);
        chk_pred("R9", res_pred, exp_pred(1, '1, '1));

        // R4 R5: irregular masks with upper group bits set, every width
        g = 32'hB3E1_5A0F;
        apply(2'd1, 1'b0, fill(1, 64'h4000), fill(1, 64'h3C00), g);
        chk_pred("R4/R5 half", res_pred, g & 32'h5555_5555);
        apply(2'd2, 1'b0, fill(2, 64'h40000000), fill(2, 64'h3F800000), g);
        chk_pred("R4/R5 single", res_pred, g & 32'h1111_1111);
        apply(2'd3, 1'b1, fill(3, 64'h4000000000000000), fill(3, 64'h3FF0000000000000), g);
        chk_pred("R4/R5 double", res_pred, g & 32'h0101_0101);
        apply(2'd2, 1'b0, fill(2, 64'h40000000), fill(2, 64'h3F800000), 32'hEEEE_EEEE);
        chk_pred("R5 only-high-bits", res_pred, '0);

        // R6: NaN in lane 1, first inactive then active
        a = fill(1, 64'h4000);
        a[31:16] = 16'h7E00;
        apply(2'd1, 1'b0, a, fill(1, 64'h3C00), 32'hFFFF_FFFB);
        chk_pred("R6 inactive nan", res_pred, exp_pred(1, 32'hFFFF_FFFB, '1));
        chk_bit("R6 inactive nan", "invalid_op", invalid_op, 1'b0);
        apply(2'd1, 1'b0, a, fill(1, 64'h3C00), '1);
        chk_pred("R6 active nan", res_pred, exp_pred(1, '1, 16'hFFFD));
        chk_bit("R6 active nan", "invalid_op", invalid_op, 1'b1);

        // R7: all-inactive mask over NaN operands
        apply(2'd3, 1'b1, '1, '1, '0);
        chk_pred("R7", res_pred, '0);
        chk_bit("R7", "invalid_op", invalid_op, 1'b0);
        apply(2'd1, 1'b1, fill(1, 64'h0000), fill(1, 64'h0000), '0);
        chk_pred("R7 ge zeros", res_pred, '0);

        // R8: size code 0
        apply(2'd0, 1'b1, '1, '0, '1);
        chk_bit("R8", "bad_size", bad_size, 1'b1);
        chk_pred("R8", res_pred, '0);
        chk_bit("R8", "invalid_op", invalid_op, 1'b0);

        // R1: reset clears a non-zero result
        apply(2'd1, 1'b1, fill(1, 64'h4000), fill(1, 64'h3C00), '1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_pred("R1 mid-run", res_pred, '0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule